// File: doc/BRIEF.md
# Clock Ratio Speed Detector

The block sits in the master-clock domain and measures a frame clock. It takes each frame clock rising edge into the master-clock domain and counts the master-clock cycles from one rising edge to the next. It then sorts that count into one of twelve nominal ratio classes. Each pair of neighbouring classes belongs to one sampling-speed tier: hex, oct, quad, double or normal. A small hysteresis filter reports a new tier only after the same class has been seen on four frames in a row.

A mode input chooses between automatic detection and manual setting. In manual setting only the slower ratios are accepted, and the reported tier is always normal. A missing frame clock is caught by a timeout. The timeout drops the lock and flags the measurement as invalid.

Top module: `clk_ratio_speed_det`

## Requirements
- R1: While `rst_n` is low and after it is released, `speed_code` is 0, `locked` is 0, `ratio_invalid` is 0 and `ratio_class` is 15 (none), until a class has been accepted.
- R2: In automatic mode (`auto_mode`=1), periods of 32 and 48 master cycles select hex (`speed_code`=4). Periods of 64 and 96 select oct (3).
- R3: In automatic mode, periods of 128 and 192 select quad (2). Periods of 256 and 384 select double (1).
- R4: In automatic mode, periods of 512, 768, 1024 and 1152 all select normal (0).
- R5: `ratio_class` gives the accepted class index: 0=32, 1=48, 2=64, 3=96, 4=128, 5=192, 6=256, 7=384, 8=512, 9=768, 10=1024, 11=1152.
- R6: A period within ±2 master cycles of a nominal ratio is accepted as that ratio. For example, 130 and 190 are accepted.
- R7: A period that matches no nominal ratio raises `ratio_invalid`. It leaves `speed_code`, `ratio_class` and `locked` unchanged. The next accepted period clears `ratio_invalid`.
- R8: `locked` rises, and `speed_code` and `ratio_class` change, only when the same class has been accepted on 4 consecutive measured periods. Fewer consecutive periods leave the old values.
- R9: In manual mode (`auto_mode`=0), only classes 7 to 11 (384 to 1152) are accepted, and `speed_code` is reported as 0 (normal). A period of 256 or less raises `ratio_invalid`.
- R10: If no frame rising edge is seen for 2048 master cycles, `locked` is cleared and `ratio_invalid` is set, and `speed_code` is held. The first edge after a timeout only starts a new window and gives no measurement.
- R11: The period is the count of master cycles between synchronized frame rising edges. An edge that arrives exactly 2047 cycles after the last one is measured, and the period is rejected without a timeout. A gap of 2048 cycles times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame clock, asynchronous to mclk |
| auto_mode | input | 1 | 1 = automatic detection, 0 = manual setting |
| speed_code | output | 3 | 0 normal, 1 double, 2 quad, 3 oct, 4 hex |
| ratio_class | output | 4 | Index of the accepted ratio class, 15 when none |
| locked | output | 1 | Stable classification held |
| ratio_invalid | output | 1 | Last period rejected, or frame clock missing |

## Verification
The frame edge that closes a measurement window and the no-edge timeout compete for the same counter value, and can fall in the same cycle. The bench provokes this with frame periods of exactly 2047 and 2048 master cycles. These put the edge in the timeout cycle or one cycle after it. The 2047 case is judged correct when `locked` stays high and only `ratio_invalid` rises. The 2048 case is judged correct when `locked` drops and the following stream needs one extra edge before it locks again.

// File: rtl/crsd_pkg.sv
// Package: shared constants and the ratio table for the clock ratio speed detector.
// Assumes ratios up to 1152 master cycles, so a 12-bit counter is enough.
package crsd_pkg;

    localparam int NUM_CLASSES = 12;
    localparam int CLASS_W     = 4;
    localparam logic [CLASS_W-1:0] CLASS_NONE = 4'hF;

    typedef enum logic [2:0] {
        SPD_NORMAL = 3'd0,
        SPD_DOUBLE = 3'd1,
        SPD_QUAD   = 3'd2,
        SPD_OCT    = 3'd3,
        SPD_HEX    = 3'd4
    } speed_t;

    // Nominal master cycles per frame for class index idx.
    // Classes come in pairs per tier: 2^k * 32 and 1.5 times that; the last two are 1024 and 1152.
    function automatic int nominal_ratio(input int idx);
        int base;
        if (idx == 10) return 1024;
        if (idx == 11) return 1152;
        base = 32 << (idx / 2);
        return (idx % 2 == 1) ? (base * 3) / 2 : base;
    endfunction

    // Speed tier of a class in automatic mode.
    function automatic speed_t auto_speed(input logic [CLASS_W-1:0] idx);
        case (idx)
            4'd0, 4'd1: return SPD_HEX;
            4'd2, 4'd3: return SPD_OCT;
            4'd4, 4'd5: return SPD_QUAD;
            4'd6, 4'd7: return SPD_DOUBLE;
            default:    return SPD_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/crsd_edge_sync.sv
// Module: crsd_edge_sync
// Brings the asynchronous frame clock into the master domain through two flops,
// then gives a one-cycle pulse on each synchronized rising edge.
// Assumes the frame clock stays high and low for at least two master cycles each.
module crsd_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising-edge pulse on the synchronized level.
    always_comb rise_pulse = sync_q & ~prev_q;

endmodule

// File: rtl/crsd_period_counter.sv
// Module: crsd_period_counter
// Counts master cycles between frame edge pulses. On an edge it presents the count as a
// measurement, unless no window was open (after reset or after a timeout).
// With no edge for TIMEOUT_CYC cycles it pulses timeout once and saturates.
module crsd_period_counter #(
    parameter int TIMEOUT_CYC = 2048,
    parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_pulse,
    output logic             meas_strobe,
    output logic [CNT_W-1:0] meas_count,
    output logic             timeout_pulse
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             window_open_q;

    // Window counter: restart on edge, count up, saturate at the timeout value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q         <= '0;
            window_open_q <= 1'b0;
        end else if (edge_pulse) begin
            cnt_q         <= CNT_W'(1);
            window_open_q <= 1'b1;
        end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_LAST) window_open_q <= 1'b0;
        end
    end

    // Measurement and timeout outputs; an edge in the last cycle wins over the timeout.
    always_comb begin
        meas_strobe   = edge_pulse & window_open_q;
        meas_count    = cnt_q;
        timeout_pulse = ~edge_pulse & (cnt_q == CNT_LAST);
    end

endmodule

// File: rtl/crsd_ratio_classifier.sv
// Module: crsd_ratio_classifier
// Combinational matcher: compares a measured period against every nominal ratio within
// a ±TOL window and returns the class index, its tier and whether it is allowed in this mode.
// Assumes the tolerance windows do not overlap.
module crsd_ratio_classifier #(
    parameter int CNT_W          = 12,
    parameter int TOL            = 2,
    parameter int MANUAL_MIN_IDX = 7
) (
    input  logic                          auto_mode,
    input  logic [CNT_W-1:0]              meas_count,
    output logic                          class_ok,
    output logic [crsd_pkg::CLASS_W-1:0]  class_idx,
    output logic [2:0]                    class_speed
);
    import crsd_pkg::*;

    logic [NUM_CLASSES-1:0] hit;

    // One window comparator per nominal ratio.
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_win
        localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(g) - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(g) + TOL);
        assign hit[g] = (meas_count >= LO) && (meas_count <= HI);
    end

    // Encode the hit, then apply the mode mask and the tier map.
    always_comb begin
        logic any_hit;
        any_hit   = 1'b0;
        class_idx = CLASS_NONE;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (hit[i] && !any_hit) begin
                any_hit   = 1'b1;
                class_idx = CLASS_W'(i);
            end
        end
        if (auto_mode) begin
            class_ok    = any_hit;
            class_speed = auto_speed(class_idx);
        end else begin
            class_ok    = any_hit && (class_idx >= CLASS_W'(MANUAL_MIN_IDX));
            class_speed = SPD_NORMAL;
        end
    end

endmodule

// File: rtl/crsd_lock_filter.sv
// Module: crsd_lock_filter
// Hysteresis on accepted classes. A class must repeat LOCK_RUN times in a row before the
// reported tier and class move and lock asserts. A rejected period only raises the invalid
// flag; a timeout drops the lock.
// Assumes meas_strobe and timeout_pulse never fall in the same cycle.
module crsd_lock_filter #(
    parameter int LOCK_RUN = 4,
    parameter int RUN_W    = $clog2(LOCK_RUN + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          meas_strobe,
    input  logic                          timeout_pulse,
    input  logic                          class_ok,
    input  logic [crsd_pkg::CLASS_W-1:0]  class_idx,
    input  logic [2:0]                    class_speed,
    output logic [2:0]                    speed_q,
    output logic [crsd_pkg::CLASS_W-1:0]  class_q,
    output logic                          locked_q,
    output logic                          invalid_q
);
    import crsd_pkg::*;

    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);

    logic [CLASS_W-1:0] cand_q;
    logic [RUN_W-1:0]   run_q;
    logic [RUN_W-1:0]   run_next;

    // Length of the run of equal classes, counting the current measurement.
    always_comb begin
        if (class_idx == cand_q && run_q != '0)
            run_next = (run_q == RUN_FULL) ? RUN_FULL : run_q + RUN_W'(1);
        else
            run_next = RUN_W'(1);
    end

    // Candidate tracking, lock and reported values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= CLASS_NONE;
            run_q     <= '0;
            speed_q   <= SPD_NORMAL;
            class_q   <= CLASS_NONE;
            locked_q  <= 1'b0;
            invalid_q <= 1'b0;
        end else if (timeout_pulse) begin
            run_q     <= '0;
            locked_q  <= 1'b0;
            invalid_q <= 1'b1;
        end else if (meas_strobe) begin
            if (!class_ok) begin
                run_q     <= '0;
                invalid_q <= 1'b1;
            end else begin
                invalid_q <= 1'b0;
                cand_q    <= class_idx;
                run_q     <= run_next;
                if (run_next == RUN_FULL) begin
                    locked_q <= 1'b1;
                    speed_q  <= class_speed;
                    class_q  <= class_idx;
                end
            end
        end
    end

endmodule

// File: rtl/clk_ratio_speed_det.sv
// Module: clk_ratio_speed_det (top)
// Measures master cycles per frame clock period, classifies the ratio into a speed tier,
// and reports it through a lock filter. auto_mode=0 restricts to the slow ratios.
// Assumes rst_n is synchronous to mclk and frame_clk is asynchronous.
module clk_ratio_speed_det #(
    parameter int TIMEOUT_CYC    = 2048,
    parameter int TOL            = 2,
    parameter int LOCK_RUN       = 4,
    parameter int MANUAL_MIN_IDX = 7
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       auto_mode,
    output logic [2:0] speed_code,
    output logic [3:0] ratio_class,
    output logic       locked,
    output logic       ratio_invalid
);
    import crsd_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic               edge_pulse;
    logic               meas_strobe;
    logic [CNT_W-1:0]   meas_count;
    logic               timeout_pulse;
    logic               class_ok;
    logic [CLASS_W-1:0] class_idx;
    logic [2:0]         class_speed;

    crsd_edge_sync i_sync (
        .clk        (mclk),
        .rst_n      (rst_n),
        .async_in   (frame_clk),
        .rise_pulse (edge_pulse)
    );

    crsd_period_counter #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) i_cnt (
        .clk           (mclk),
        .rst_n         (rst_n),
        .edge_pulse    (edge_pulse),
        .meas_strobe   (meas_strobe),
        .meas_count    (meas_count),
        .timeout_pulse (timeout_pulse)
    );

    crsd_ratio_classifier #(
        .CNT_W          (CNT_W),
        .TOL            (TOL),
        .MANUAL_MIN_IDX (MANUAL_MIN_IDX)
    ) i_cls (
        .auto_mode   (auto_mode),
        .meas_count  (meas_count),
        .class_ok    (class_ok),
        .class_idx   (class_idx),
        .class_speed (class_speed)
    );

    crsd_lock_filter #(
        .LOCK_RUN (LOCK_RUN)
    ) i_flt (
        .clk           (mclk),
        .rst_n         (rst_n),
        .meas_strobe   (meas_strobe),
        .timeout_pulse (timeout_pulse),
        .class_ok      (class_ok),
        .class_idx     (class_idx),
        .class_speed   (class_speed),
        .speed_q       (speed_code),
        .class_q       (ratio_class),
        .locked_q      (locked),
        .invalid_q     (ratio_invalid)
    );

endmodule

// File: rtl/crsd_checker.sv
// Module: crsd_checker
// Temporal properties of the speed detector, bound to the top module.
module crsd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_mode,
    input logic [2:0] speed_code,
    input logic       locked,
    input logic       ratio_invalid,
    input logic       timeout_pulse,
    input logic       meas_strobe
);

    a_r10_timeout_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> (!locked && ratio_invalid));

    // R7: a rejected period never drops the lock; only a timeout does.
    a_r7_lock_falls_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(timeout_pulse));

    a_r8_speed_moves_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_code) |-> locked);

    a_r9_manual_reports_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(speed_code) && !$past(auto_mode)) |-> (speed_code == 3'd0));

    a_r2_speed_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        speed_code <= 3'd4);

    a_r11_edge_beats_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_pulse && meas_strobe));

endmodule

bind clk_ratio_speed_det crsd_checker i_crsd_checker (
    .clk           (mclk),
    .rst_n         (rst_n),
    .auto_mode     (auto_mode),
    .speed_code    (speed_code),
    .locked        (locked),
    .ratio_invalid (ratio_invalid),
    .timeout_pulse (timeout_pulse),
    .meas_strobe   (meas_strobe)
);

// File: tb/test_clk_ratio_speed_det.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each task checks its own results at the ports.
module test_clk_ratio_speed_det;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       auto_mode = 1'b1;
    logic [2:0] speed_code;
    logic [3:0] ratio_class;
    logic       locked;
    logic       ratio_invalid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 mclk = ~mclk;

    clk_ratio_speed_det i_clk_ratio_speed_det (
        .mclk          (mclk),
        .rst_n         (rst_n),
        .frame_clk     (frame_clk),
        .auto_mode     (auto_mode),
        .speed_code    (speed_code),
        .ratio_class   (ratio_class),
        .locked        (locked),
        .ratio_invalid (ratio_invalid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int spd, input int cls,
                               input int lck, input int inv);
        check({req, " speed_code"},    int'(speed_code),    spd);
        check({req, " ratio_class"},   int'(ratio_class),   cls);
        check({req, " locked"},        int'(locked),        lck);
        check({req, " ratio_invalid"}, int'(ratio_invalid), inv);
    endtask

    // k frame periods of n master cycles; inputs change on the falling edge.
    task automatic frames(input int n, input int k);
        for (int f = 0; f < k; f++) begin
            @(negedge mclk) frame_clk = 1'b1;
            repeat (n / 2 - 1) @(negedge mclk);
            @(negedge mclk) frame_clk = 1'b0;
            repeat (n - n / 2 - 1) @(negedge mclk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge mclk);
        check_state("R1 in reset", 0, 15, 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge mclk);
        check_state("R1 after reset", 0, 15, 0, 0);
    endtask

    task automatic t_auto_normal_and_hysteresis;
        auto_mode = 1'b1;
        frames(512, 5);
        check_state("R4 R5 auto 512", 0, 8, 1, 0);
        frames(256, 3);
        check_state("R8 two periods of 256 hold old tier", 0, 8, 1, 0);
        frames(256, 2);
        check_state("R3 R8 four periods of 256", 1, 6, 1, 0);
        frames(384, 5);
        check_state("R3 auto 384", 1, 7, 1, 0);
    endtask

    task automatic t_tolerance_and_reject;
        frames(130, 5);
        check_state("R6 R3 period 130 as 128", 2, 4, 1, 0);
        frames(190, 5);
        check_state("R6 R3 period 190 as 192", 2, 5, 1, 0);
        frames(131, 2);
        check_state("R7 period 131 rejected", 2, 5, 1, 1);
    endtask

    task automatic t_fast_tiers;
        frames(32, 5);
        check_state("R2 R7 auto 32 clears invalid", 4, 0, 1, 0);
        frames(48, 5);
        check_state("R2 auto 48", 4, 1, 1, 0);
        frames(64, 5);
        check_state("R2 auto 64", 3, 2, 1, 0);
        frames(96, 5);
        check_state("R2 auto 96", 3, 3, 1, 0);
    endtask

    task automatic t_manual;
        auto_mode = 1'b0;
        frames(384, 5);
        check_state("R9 manual 384 reads normal", 0, 7, 1, 0);
        frames(256, 5);
        check_state("R9 manual 256 rejected", 0, 7, 1, 1);
        frames(64, 3);
        check_state("R9 manual 64 rejected", 0, 7, 1, 1);
        frames(1152, 5);
        check_state("R9 R4 manual 1152", 0, 11, 1, 0);
        auto_mode = 1'b1;
        frames(1024, 5);
        check_state("R4 auto 1024", 0, 10, 1, 0);
    endtask

    task automatic t_timeout_race;
        frames(2047, 2);
        frames(1024, 1);
        check_state("R11 period 2047 rejected without timeout", 0, 10, 1, 1);
        frames(2048, 2);
        check_state("R10 R11 gap 2048 times out", 0, 10, 0, 1);
        frames(768, 5);
        check_state("R10 relock needs one extra edge", 0, 9, 1, 0);
        repeat (2100) @(negedge mclk);
        check_state("R10 frame clock stopped", 0, 9, 0, 1);
    endtask

    initial begin
        t_reset();
        t_auto_normal_and_hysteresis();
        t_tolerance_and_reject();
        t_fast_tiers();
        t_manual();
        t_timeout_race();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge mclk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule